// File: doc/BRIEF.md
# Gray-Sequenced Controller with Transition Guard

This block is a small cyclic controller whose state register walks through a six-code reflected Gray sequence. The code advances by one position on each clock where the advance input is high. The sequence is taken symmetrically from the ends of the 3-bit reflected Gray cycle, so the wrap from the last code back to home also flips a single bit. A guard runs beside the sequencer and keeps a registered copy of the previous state. It XORs that copy with the current state and raises a sticky error flag whenever more than one bit changed between two clocks. It also decodes the two codes that are outside the sequence and flags them.

When either condition is seen, the machine is forced to the home code on the next clock. The flag stays set until the clear input is pulsed. A test input can overwrite the state register with any value. This lets a bench model a single-event upset and watch detection and recovery at the ports.

Top module: `gray_seq_guard`

## Requirements
- R1: While the active-low reset is asserted, and on the first cycle after it is released, state_o is 3'b000, home_o is 1 and err_o is 0.
- R2: With adv_i high on consecutive clocks, state_o takes the values 000, 001, 011, 111, 101, 100 and then 000 again. It moves one position per rising edge.
- R3: With adv_i low and no fault, state_o holds its value and err_o stays 0.
- R4: home_o is 1 exactly when state_o is 3'b000.
- R5: If state_o differs from its value one clock earlier in more than one bit, err_o is 1 after the next rising edge.
- R6: If state_o holds an unused code (3'b010 or 3'b110), err_o is set and state_o returns to 3'b000 at the next rising edge.
- R7: After a multi-bit change between two legal codes, state_o returns to 3'b000 at the next rising edge, whatever adv_i is.
- R8: err_o is sticky and is cleared only by err_clr_i. If a new fault and a clear fall on the same edge, the fault wins.
- R9: An injected change of exactly one bit into a legal code is not flagged, and the sequence continues from the new code.
- R10: When inj_en_i is high, state_o takes inj_code_i at the next edge and adv_i has no effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Step to the next code in the sequence |
| err_clr_i | input | 1 | Clear the sticky error flag |
| inj_en_i | input | 1 | Test only: overwrite the state register |
| inj_code_i | input | STATE_W | Test only: value written when inj_en_i is high |
| state_o | output | STATE_W | Current state code |
| home_o | output | 1 | High in the home code 000 |
| err_o | output | 1 | Sticky illegal-transition or unused-code flag |

## Verification
An upset in the state register shows at the ports one edge after it happens. If it flipped more than one bit or landed on an unused code, err_o rises and state_o snaps to 000 on that same edge. If it flipped a single bit into a legal code, state_o simply continues from the new position with no flag, and only the altered sequence reveals it. The recovery jump to home is itself a multi-bit change in most cases, so the flag is set again one edge later. A clear therefore only sticks once two quiet edges have passed.

// File: rtl/gray_guard_pkg.sv
package gray_guard_pkg;

  localparam int GG_MAXW = 16;
  typedef logic [GG_MAXW-1:0] gg_word_t;

  function automatic gg_word_t bin2gray(gg_word_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic gg_word_t gray2bin(gg_word_t g);
    gg_word_t b;
    b = g;
    for (int i = GG_MAXW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // used codes: first n/2 and last n/2 positions of the full reflected cycle
  function automatic logic code_is_used(gg_word_t g, int w, int n);
    int j;
    j = int'(gray2bin(g));
    return (j < n / 2) || (j >= (1 << w) - n / 2);
  endfunction

  function automatic gg_word_t next_code(gg_word_t g, int w, int n);
    int j;
    j = int'(gray2bin(g));
    if (j == n / 2 - 1) j = (1 << w) - n / 2;
    else if (j == (1 << w) - 1) j = 0;
    else j = j + 1;
    return bin2gray(gg_word_t'(j));
  endfunction

endpackage

// File: rtl/gray_step.sv
module gray_step
  import gray_guard_pkg::*;
#(
  parameter int STATE_W    = 3,
  parameter int NUM_STATES = 6
) (
  input  logic [STATE_W-1:0] cur_i,
  output logic [STATE_W-1:0] nxt_o,
  output logic               used_o
);

  always_comb begin
    used_o = code_is_used(gg_word_t'(cur_i), STATE_W, NUM_STATES);
    nxt_o  = STATE_W'(next_code(gg_word_t'(cur_i), STATE_W, NUM_STATES));
  end

endmodule

// File: rtl/gray_guard_cmp.sv
module gray_guard_cmp #(
  parameter int STATE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] cur_i,
  output logic [STATE_W-1:0] last_o,
  output logic               multi_o
);

  logic [STATE_W-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_o <= '0;
    else        last_o <= cur_i;
  end

  always_comb begin
    diff    = cur_i ^ last_o;
    multi_o = ($countones(diff) > 1);
  end

endmodule

// File: rtl/gray_seq_guard.sv
module gray_seq_guard #(
  parameter int STATE_W    = 3,
  parameter int NUM_STATES = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  input  logic               err_clr_i,
  input  logic               inj_en_i,
  input  logic [STATE_W-1:0] inj_code_i,
  output logic [STATE_W-1:0] state_o,
  output logic               home_o,
  output logic               err_o
);

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] step_code;
  logic [STATE_W-1:0] last_code;
  logic               code_ok;
  logic               multi_flip;
  logic               fault;
  logic               err_q;

  gray_step #(.STATE_W(STATE_W), .NUM_STATES(NUM_STATES)) u_step (
    .cur_i (state_q),
    .nxt_o (step_code),
    .used_o(code_ok)
  );

  gray_guard_cmp #(.STATE_W(STATE_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (state_q),
    .last_o (last_code),
    .multi_o(multi_flip)
  );

  assign fault = multi_flip || !code_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (inj_en_i) state_q <= inj_code_i;
    else if (fault)    state_q <= '0;
    else if (adv_i)    state_q <= step_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (fault)     err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign state_o = state_q;
  assign home_o  = (state_q == '0);
  assign err_o   = err_q;

  // R5
  multi_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_flip |=> err_q);

  // R7
  multi_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_flip && !inj_en_i) |=> (state_q == '0));

  // R6
  unused_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_ok && !inj_en_i) |=> (state_q == '0) && err_q);

  // R2
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !inj_en_i && !fault) |=> ($countones(state_q ^ $past(state_q)) == 1));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !inj_en_i && !fault) |=> $stable(state_q));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr_i) |=> err_q);

endmodule

// File: tb/gray_seq_guard_bench.sv
module gray_seq_guard_bench;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adv_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic       inj_en_i = 1'b0;
  logic [2:0] inj_code_i = 3'b000;
  logic [2:0] state_o;
  logic       home_o;
  logic       err_o;

  int checks = 0;
  int failures = 0;

  gray_seq_guard u_gray_seq_guard (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .err_clr_i(err_clr_i),
    .inj_en_i(inj_en_i), .inj_code_i(inj_code_i),
    .state_o(state_o), .home_o(home_o), .err_o(err_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset();
    adv_i = 0; err_clr_i = 0; inj_en_i = 0; inj_code_i = 0;
    rst_n = 0;
    step();
    rst_n = 1;
  endtask

  task automatic t_reset();
    rst_n = 0; #1;
    chk(state_o, 0, "R1 state in reset");
    chk(home_o, 1, "R1 home in reset");
    chk(err_o, 0, "R1 err in reset");
    do_reset();
    step();
    chk(state_o, 0, "R1 state after release");
    chk(home_o, 1, "R4 home at 000");
  endtask

  task automatic t_walk();
    logic [2:0] seq [7] = '{3'b001, 3'b011, 3'b111, 3'b101, 3'b100, 3'b000, 3'b001};
    do_reset();
    adv_i = 1;
    for (int k = 0; k < 7; k++) begin
      step();
      chk(state_o, seq[k], $sformatf("R2 walk position %0d", k));
      chk(home_o, (seq[k] == 3'b000) ? 1 : 0, "R4 home decode");
    end
    adv_i = 0;
    chk(err_o, 0, "R2 no flag on legal walk");
  endtask

  task automatic t_hold();
    do_reset();
    adv_i = 1; step(); step();
    adv_i = 0;
    for (int k = 0; k < 4; k++) begin
      step();
      chk(state_o, 3'b011, "R3 hold");
    end
    chk(err_o, 0, "R3 no flag while holding");
  endtask

  task automatic t_unused();
    do_reset();
    adv_i = 1; step(); step();
    adv_i = 0;
    inj_en_i = 1; inj_code_i = 3'b010; step();
    inj_en_i = 0;
    chk(state_o, 3'b010, "R6 injected unused code visible");
    chk(err_o, 0, "R6 single-bit change not yet flagged");
    step();
    chk(state_o, 0, "R6 unused code returns home");
    chk(err_o, 1, "R6 unused code flagged");
    err_clr_i = 1; step(); err_clr_i = 0;
    inj_en_i = 1; inj_code_i = 3'b110; step();
    inj_en_i = 0;
    adv_i = 1; step(); adv_i = 0;
    chk(state_o, 0, "R6 code 110 returns home");
    chk(err_o, 1, "R6 code 110 flagged");
  endtask

  task automatic t_multi();
    do_reset();
    adv_i = 1; step();
    inj_en_i = 1; inj_code_i = 3'b111; step();
    inj_en_i = 0;
    chk(err_o, 0, "R5 flag not before detection edge");
    step();
    chk(err_o, 1, "R5 multi-bit change flagged");
    chk(state_o, 0, "R7 multi-bit change forces home despite adv");
    adv_i = 0;
  endtask

  task automatic t_sticky();
    do_reset();
    inj_en_i = 1; inj_code_i = 3'b101; step();
    inj_en_i = 0;
    step();
    chk(err_o, 1, "R8 flag set");
    step(); step(); step();
    chk(err_o, 1, "R8 flag sticky without clear");
    err_clr_i = 1; step(); err_clr_i = 0;
    chk(err_o, 0, "R8 clear drops flag");
    inj_en_i = 1; inj_code_i = 3'b011; step();
    inj_en_i = 0;
    err_clr_i = 1; step(); err_clr_i = 0;
    chk(err_o, 1, "R8 fault wins over clear");
  endtask

  task automatic t_single_inject();
    do_reset();
    inj_en_i = 1; inj_code_i = 3'b100; step();
    inj_en_i = 0;
    step();
    chk(err_o, 0, "R9 single-bit legal upset not flagged");
    chk(state_o, 3'b100, "R9 state kept at upset code");
    adv_i = 1; step(); adv_i = 0;
    chk(state_o, 3'b000, "R9 sequence continues from upset code");
  endtask

  task automatic t_inject_priority();
    do_reset();
    adv_i = 1; step();
    inj_en_i = 1; inj_code_i = 3'b000; step();
    inj_en_i = 0; adv_i = 0;
    chk(state_o, 0, "R10 inject overrides adv");
    step();
    chk(err_o, 0, "R10 one-bit inject not flagged");
  endtask

  initial begin
    #(CLK_P * 20000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_walk();
    t_hold();
    t_unused();
    t_multi();
    t_sticky();
    t_single_inject();
    t_inject_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule